// File: doc/BRIEF.md
# Scaled Integer Add and Compare Unit

This block is a 64-bit integer execution slice for a processor datapath. It decodes a 7-bit function code and forms one of four kinds of result: a sum or difference, optionally with operand A pre-scaled by 4 or 8; a signed or unsigned magnitude compare that yields 0 or 1; an equality test; or a byte-parallel compare that yields an 8-bit mask. Every arithmetic operation has a 64-bit (quadword) form and a 32-bit (longword) form. A longword result is sign-extended to 64 bits.

Operand B is either the register value or an 8-bit literal, zero-extended to 64 bits. Four function codes also check for signed overflow. An unknown code gives a zero result and raises an illegal-operation flag. The result and both flags are captured one clock after the input strobe. Delivering traps is left to the consumer of the flags.

Top module: `int_arith_unit`

## Requirements
- R1: Code 0x20 gives A+B and code 0x29 gives A-B, both modulo 2^64.
- R2: Longword codes 0x00 (add) and 0x09 (subtract) work on A[31:0] and B[31:0]. The 32-bit result is sign-extended into bits 63:32, and the upper 32 bits of the operands have no effect.
- R3: Scaled codes multiply A by 4 or by 8 before the add or subtract. For add, 0x02 and 0x22 scale by 4, 0x12 and 0x32 scale by 8. For subtract, 0x0b and 0x2b scale by 4, 0x1b and 0x3b scale by 8. Codes below 0x20 are longword forms and the others are quadword forms.
- R4: The add codes 0x40 (longword) and 0x60 (quadword) give the same result as 0x00 and 0x20. They raise ovf_o when A and B have equal sign bits and the sign bit of the result differs from the sign bit of A. The sign bit is bit 31 for longword and bit 63 for quadword.
- R5: The subtract codes 0x49 (longword) and 0x69 (quadword) give the same result as 0x09 and 0x29. They raise ovf_o when A and B have different sign bits and the sign bit of the result differs from the sign bit of A.
- R6: ovf_o is 0 for every code other than 0x40, 0x60, 0x49 and 0x69, even when the arithmetic wraps.
- R7: The compare codes give 1 when their test holds and 0 otherwise. The codes are 0x2d (A==B), 0x6d (signed A<=B), 0x4d (signed A<B), 0x3d (unsigned A<=B) and 0x1d (unsigned A<B).
- R8: Code 0x0f sets result bit i, for i = 0..7, when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B. Result bits 63:8 are 0.
- R9: When lit_sel_i is 1, operand B is {56'b0, lit_i} and opb_i has no effect.
- R10: Any code not listed in R1 to R8 gives result 0 and ovf_o 0, with illegal_o set to 1. illegal_o is 0 for every listed code.
- R11: valid_o follows valid_i by one clock. The result and both flags update only on clocks where valid_i is 1, and hold their value otherwise.
- R12: While rst_ni is low, valid_o, result_o, ovf_o and illegal_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B register value |
| lit_sel_i | input | 1 | Select literal as operand B |
| lit_i | input | 8 | Literal operand |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Signed overflow flag |
| illegal_o | output | 1 | Unknown function code flag |

## Verification
The only state in this block is the output register, so an internal fault shows at the ports on the very clock that follows the operation.

- A wrong decode appears as the wrong result value, a stray overflow or illegal flag, or upper bits set after a compare.
- A fault in the capture enable appears as a result that changes during an idle cycle.

The reference model is updated every cycle, so either kind of fault is caught at the first cycle where it occurs.

// File: rtl/int_arith_pkg.sv
package int_arith_pkg;
  localparam int FUNC_W = 7;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_CEQ, OP_CSLE, OP_CSLT, OP_CULE, OP_CULT, OP_BGE, OP_ILL
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       is_long;
    logic [1:0] shamt;
    logic       chk_ovf;
  } dec_t;
endpackage

// File: rtl/iau_decode.sv
module iau_decode
  import int_arith_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '{kind: OP_ILL, is_long: 1'b0, shamt: 2'd0, chk_ovf: 1'b0};
    unique case (func_i)
      7'h00: dec_o = '{OP_ADD, 1'b1, 2'd0, 1'b0};
      7'h40: dec_o = '{OP_ADD, 1'b1, 2'd0, 1'b1};
      7'h02: dec_o = '{OP_ADD, 1'b1, 2'd2, 1'b0};
      7'h12: dec_o = '{OP_ADD, 1'b1, 2'd3, 1'b0};
      7'h20: dec_o = '{OP_ADD, 1'b0, 2'd0, 1'b0};
      7'h60: dec_o = '{OP_ADD, 1'b0, 2'd0, 1'b1};
      7'h22: dec_o = '{OP_ADD, 1'b0, 2'd2, 1'b0};
      7'h32: dec_o = '{OP_ADD, 1'b0, 2'd3, 1'b0};
      7'h09: dec_o = '{OP_SUB, 1'b1, 2'd0, 1'b0};
      7'h49: dec_o = '{OP_SUB, 1'b1, 2'd0, 1'b1};
      7'h0b: dec_o = '{OP_SUB, 1'b1, 2'd2, 1'b0};
      7'h1b: dec_o = '{OP_SUB, 1'b1, 2'd3, 1'b0};
      7'h29: dec_o = '{OP_SUB, 1'b0, 2'd0, 1'b0};
      7'h69: dec_o = '{OP_SUB, 1'b0, 2'd0, 1'b1};
      7'h2b: dec_o = '{OP_SUB, 1'b0, 2'd2, 1'b0};
      7'h3b: dec_o = '{OP_SUB, 1'b0, 2'd3, 1'b0};
      7'h2d: dec_o.kind = OP_CEQ;
      7'h6d: dec_o.kind = OP_CSLE;
      7'h4d: dec_o.kind = OP_CSLT;
      7'h3d: dec_o.kind = OP_CULE;
      7'h1d: dec_o.kind = OP_CULT;
      7'h0f: dec_o.kind = OP_BGE;
      default: dec_o.kind = OP_ILL;
    endcase
  end
endmodule

// File: rtl/iau_addsub.sv
module iau_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              is_long_i,
  input  logic [1:0]        shamt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] a_sc, sum;
  logic sa, sb, sr;

  always_comb begin
    a_sc = a_i << shamt_i;
    sum  = sub_i ? (a_sc - b_i) : (a_sc + b_i);
    res_o = is_long_i ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
    // sign taps follow operand width; A sign is the unscaled one
    sa = is_long_i ? a_i[HALF-1] : a_i[DATA_W-1];
    sb = is_long_i ? b_i[HALF-1] : b_i[DATA_W-1];
    sr = is_long_i ? sum[HALF-1] : sum[DATA_W-1];
    ovf_o = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/iau_compare.sv
module iau_compare #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  output logic                     eq_o,
  output logic                     slt_o,
  output logic                     ult_o,
  output logic [DATA_W/BYTE_W-1:0] byte_ge_o
);
  localparam int NBYTE = DATA_W / BYTE_W;

  assign eq_o  = (a_i == b_i);
  assign slt_o = ($signed(a_i) < $signed(b_i));
  assign ult_o = (a_i < b_i);

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign byte_ge_o[i] = (a_i[i*BYTE_W +: BYTE_W] >= b_i[i*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
  import int_arith_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [6:0]        func_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              lit_sel_i,
  input  logic [LIT_W-1:0]  lit_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o,
  output logic              illegal_o
);
  localparam int NBYTE = DATA_W / BYTE_W;

  dec_t              dec;
  logic [DATA_W-1:0] b_op, as_res, res_d;
  logic              as_ovf, eq, slt, ult, ovf_d, ill_d;
  logic [NBYTE-1:0]  bge;

  assign b_op = lit_sel_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : opb_i;

  iau_decode u_dec (.func_i(func_i), .dec_o(dec));

  iau_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(opa_i), .b_i(b_op), .sub_i(dec.kind == OP_SUB),
    .is_long_i(dec.is_long), .shamt_i(dec.shamt),
    .res_o(as_res), .ovf_o(as_ovf)
  );

  iau_compare #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cmp (
    .a_i(opa_i), .b_i(b_op), .eq_o(eq), .slt_o(slt), .ult_o(ult),
    .byte_ge_o(bge)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    ill_d = 1'b0;
    unique case (dec.kind)
      OP_ADD, OP_SUB: begin
        res_d = as_res;
        ovf_d = dec.chk_ovf & as_ovf;
      end
      OP_CEQ:  res_d[0] = eq;
      OP_CSLE: res_d[0] = slt | eq;
      OP_CSLT: res_d[0] = slt;
      OP_CULE: res_d[0] = ult | eq;
      OP_CULT: res_d[0] = ult;
      OP_BGE:  res_d[NBYTE-1:0] = bge;
      default: ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      ovf_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        ovf_o     <= ovf_d;
        illegal_o <= ill_d;
      end
    end
  end
endmodule

// File: rtl/iau_checker.sv
module iau_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [6:0]  func_i,
  input logic        valid_o,
  input logic [63:0] result_o,
  input logic        ovf_o,
  input logic        illegal_o
);
  logic f_ovf, f_cmp, f_bge;
  assign f_ovf = (func_i == 7'h40) || (func_i == 7'h60) ||
                 (func_i == 7'h49) || (func_i == 7'h69);
  assign f_cmp = (func_i == 7'h2d) || (func_i == 7'h6d) || (func_i == 7'h4d) ||
                 (func_i == 7'h3d) || (func_i == 7'h1d);
  assign f_bge = (func_i == 7'h0f);

  assert_valid_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(ovf_o) && $stable(illegal_o));
  assert_illegal_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == 64'd0) && !ovf_o);
  assert_ovf_codes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !f_ovf) |=> !ovf_o);
  assert_cmp_bit0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f_cmp) |=> (result_o[63:1] == 63'd0) && !illegal_o);
  assert_bge_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f_bge) |=> (result_o[63:8] == 56'd0) && !illegal_o);
endmodule

bind int_arith_unit iau_checker u_iau_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
  .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
);

// File: tb/test_int_arith_unit.sv
`timescale 1ns/1ps
module test_int_arith_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [6:0]  func_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        lit_sel_i = 1'b0;
  logic [7:0]  lit_i = '0;
  logic        valid_o, ovf_o, illegal_o;
  logic [63:0] result_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [63:0] m_res = '0;
  logic        m_val = 1'b0, m_ovf = 1'b0, m_ill = 1'b0;

  always #2 clk_i = ~clk_i;

  int_arith_unit i_int_arith_unit (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [6:0] f, input logic [63:0] a,
                                 input logic [63:0] b, output logic [63:0] r,
                                 output logic ov, output logic il);
    int k; bit lng, sub, cov, arith;
    logic signed [31:0] a32, b32;
    longint la, lb, t;
    logic signed [65:0] w;
    r = '0; ov = 0; il = 0; arith = 1; k = 1; lng = 0; sub = 0; cov = 0;
    case (f)
      7'h00: lng = 1;  7'h40: begin lng = 1; cov = 1; end
      7'h02: begin lng = 1; k = 4; end  7'h12: begin lng = 1; k = 8; end
      7'h20: ;  7'h60: cov = 1;
      7'h22: k = 4;  7'h32: k = 8;
      7'h09: begin lng = 1; sub = 1; end  7'h49: begin lng = 1; sub = 1; cov = 1; end
      7'h0b: begin lng = 1; sub = 1; k = 4; end  7'h1b: begin lng = 1; sub = 1; k = 8; end
      7'h29: sub = 1;  7'h69: begin sub = 1; cov = 1; end
      7'h2b: begin sub = 1; k = 4; end  7'h3b: begin sub = 1; k = 8; end
      default: arith = 0;
    endcase
    if (arith) begin
      if (lng) begin
        a32 = a[31:0]; b32 = b[31:0]; la = a32; lb = b32;
        t = sub ? la * k - lb : la * k + lb;
        r = {{32{t[31]}}, t[31:0]};
        ov = cov && (t > 64'sd2147483647 || t < -64'sd2147483648);
      end else begin
        r = sub ? a * k - b : a * k + b;
        w = sub ? $signed(a) - $signed(b) : $signed(a) + $signed(b);
        ov = cov && (w > 66'sh0_7FFF_FFFF_FFFF_FFFF || w < -66'sh0_8000_0000_0000_0000);
      end
      return;
    end
    case (f)
      7'h2d: r = {63'd0, a == b};
      7'h6d: r = {63'd0, $signed(a) <= $signed(b)};
      7'h4d: r = {63'd0, $signed(a) < $signed(b)};
      7'h3d: r = {63'd0, a <= b};
      7'h1d: r = {63'd0, a < b};
      7'h0f: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
      default: il = 1;
    endcase
  endfunction

  // drive at negedge, sample 1 ns after the following posedge
  task automatic step(string req, logic v, logic [6:0] f, logic [63:0] a,
                      logic [63:0] b, logic ls = 0, logic [7:0] lit = 8'h00);
    logic [63:0] r, beff; logic ov, il;
    valid_i = v; func_i = f; opa_i = a; opb_i = b; lit_sel_i = ls; lit_i = lit;
    beff = ls ? {56'd0, lit} : b;
    ref_op(f, a, beff, r, ov, il);
    @(posedge clk_i);
    m_val = v;
    if (v) begin m_res = r; m_ovf = ov; m_ill = il; end
    #1;
    chk(req, "valid", {63'd0, valid_o}, {63'd0, m_val});
    chk(req, "result", result_o, m_res);
    chk(req, "ovf", {63'd0, ovf_o}, {63'd0, m_ovf});
    chk(req, "illegal", {63'd0, illegal_o}, {63'd0, m_ill});
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12: strobe held high during reset must not be captured
    valid_i = 1'b1; func_i = 7'h7f; opa_i = '1; opb_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R12", "valid", {63'd0, valid_o}, 64'd0);
    chk("R12", "result", result_o, 64'd0);
    chk("R12", "ovf", {63'd0, ovf_o}, 64'd0);
    chk("R12", "illegal", {63'd0, illegal_o}, 64'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    step("R1", 1, 7'h20, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111);
    step("R1", 1, 7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
    step("R1", 1, 7'h29, 64'h5, 64'h7);
    step("R2", 1, 7'h00, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001);
    step("R2", 1, 7'h09, 64'hAAAA_AAAA_0000_0003, 64'h5555_5555_0000_0005);
    step("R2", 1, 7'h00, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_0010);
    step("R3", 1, 7'h02, 64'h0000_0000_4000_0001, 64'h3);
    step("R3", 1, 7'h12, 64'h0000_0000_1000_0003, 64'h1);
    step("R3", 1, 7'h22, 64'h4000_0000_0000_0001, 64'h10);
    step("R3", 1, 7'h32, 64'h2000_0000_0000_0005, 64'h7);
    step("R3", 1, 7'h0b, 64'h2, 64'h9);
    step("R3", 1, 7'h1b, 64'h0000_0000_F000_0001, 64'h1);
    step("R3", 1, 7'h2b, 64'h3, 64'h20);
    step("R3", 1, 7'h3b, 64'h8000_0000_0000_0001, 64'h2);
    step("R4", 1, 7'h40, 64'h7FFF_FFFF, 64'h1);
    step("R4", 1, 7'h40, 64'h8000_0000, 64'hFFFF_FFFF);
    step("R4", 1, 7'h40, 64'h7FFF_FFFF, 64'hFFFF_FFFF);
    step("R4", 1, 7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    step("R4", 1, 7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    step("R4", 1, 7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R5", 1, 7'h49, 64'h8000_0000, 64'h1);
    step("R5", 1, 7'h49, 64'h7FFF_FFFF, 64'hFFFF_FFFF);
    step("R5", 1, 7'h49, 64'h8000_0000, 64'hFFFF_FFFF);
    step("R5", 1, 7'h69, 64'h8000_0000_0000_0000, 64'h1);
    step("R5", 1, 7'h69, 64'h1, 64'h2);
    step("R6", 1, 7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    step("R6", 1, 7'h09, 64'h8000_0000, 64'h1);
    step("R6", 1, 7'h32, 64'h7000_0000_0000_0000, 64'h7000_0000_0000_0000);
    step("R7", 1, 7'h2d, 64'h1234, 64'h1234);
    step("R7", 1, 7'h2d, 64'h1234, 64'h1235);
    step("R7", 1, 7'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    step("R7", 1, 7'h6d, 64'h5, 64'h5);
    step("R7", 1, 7'h4d, 64'h5, 64'h5);
    step("R7", 1, 7'h4d, 64'h8000_0000_0000_0000, 64'h0);
    step("R7", 1, 7'h3d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    step("R7", 1, 7'h3d, 64'h9, 64'h9);
    step("R7", 1, 7'h1d, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R7", 1, 7'h1d, 64'h9, 64'h9);
    step("R8", 1, 7'h0f, 64'h00FF_1080_7F01_FE00, 64'h01FE_1080_8000_FF00);
    step("R8", 1, 7'h0f, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    step("R8", 1, 7'h0f, 64'h0, 64'h0101_0101_0101_0101);
    step("R9", 1, 7'h20, 64'h100, 64'hFFFF_0000_FFFF_0000, 1, 8'hF0);
    step("R9", 1, 7'h0f, 64'h0000_0000_0000_0080, 64'h0, 1, 8'h80);
    step("R9", 1, 7'h1d, 64'h7F, 64'h0, 1, 8'hFF);
    step("R10", 1, 7'h01, 64'h1234, 64'h1);
    step("R10", 1, 7'h7f, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    step("R10", 1, 7'h41, 64'h8000_0000, 64'h1);
    step("R11", 1, 7'h20, 64'hAAAA, 64'h5555);
    step("R11", 0, 7'h29, 64'h1, 64'h1);
    step("R11", 0, 7'h7f, 64'h9, 64'h9);
    step("R11", 1, 7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    step("R11", 0, 7'h20, 64'h0, 64'h0);
    step("R11", 1, 7'h2d, 64'h3, 64'h3);
    step("R11", 1, 7'h3b, 64'h3, 64'h3);
    step("R11", 0, 7'h00, 64'h0, 64'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule